// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block controls the digital side of a dual-slope integrating analog-to-digital converter. A start pulse begins a conversion. For a fixed window of 2^N clock cycles the integrator sees the unknown input. The block then switches the integrator to the negative reference and keeps counting until the comparator reports that the integrator output has come back through zero. At that point the count is frozen, and its low N bits are the digital result, proportional to Vin/Vref.

A single N+1 bit counter measures both phases. Its top bit selects the integrator's input: the unknown input while it is 0, the reference while it is 1. The low N bits wrap at the end of the fixed window and restart from zero for the de-integration phase, so no separate register is needed to hold the result.

When the comparator has not tripped within a further 2^N counts, the result is clamped to full scale and an overrange flag is raised. A one-cycle done pulse marks every capture. The sequencer then waits idle for the next start, and any start that arrives during a conversion is ignored.

Top module: `dual_slope_seq`

## Requirements
- R1: `sel_ref_o` always equals bit N of `count_o`: 0 connects the unknown input to the integrator, 1 connects the negative reference.
- R2: A start seen while idle clears `count_o` to 0 at the next edge. The count then rises by one every cycle for exactly 2^N cycles, after which the low N bits wrap to 0 and bit N becomes 1.
- R3: In the second phase the count rises by one on every cycle in which `cmp_i` is 1 (integrator output below zero).
- R4: The first second-phase cycle with `cmp_i` at 0 freezes the count, and its low N bits k are captured into `result_o`. With a linear integrator this is k = ceil(Vin*2^N/Vref), and done appears 2^N+k+1 cycles after the start edge.
- R5: If the low N bits reach all ones in the second phase while `cmp_i` is still 1, the conversion ends 2^(N+1) cycles after the start edge with `result_o` all ones and `ovr_o` = 1. A normal capture sets `ovr_o` to 0.
- R6: `done_o` is high for exactly one cycle per capture. `result_o` and `ovr_o` hold their values until the next capture, and `count_o` stays frozen while idle.
- R7: A start asserted during a conversion has no effect: the count keeps rising and the timing of the conversion is unchanged.
- R8: After reset `count_o`, `sel_ref_o`, `done_o`, `result_o` and `ovr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a conversion while idle |
| cmp_i | input | 1 | Comparator, 1 while the integrator output is below zero |
| sel_ref_o | output | 1 | Integrator input select: 0 = unknown input, 1 = reference |
| count_o | output | N+1 | Phase counter |
| done_o | output | 1 | One-cycle pulse on capture |
| result_o | output | N | Captured conversion result |
| ovr_o | output | 1 | Overrange flag of the last capture |

## Verification
The bench builds the block with N = 6, so a full window lasts 64 cycles. At that size one run can cover every trip count from zero to full scale, the overrange clamp and the exact wrap instant between phases. The integrator is modelled in integers with Vref = 100, which makes inputs near full scale round up into overrange. That rounding boundary and the zero-input case, where the trip happens on the first reference cycle, are both exercised.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2
    } ds_state_e;
endpackage

// File: rtl/ds_window_ctr.sv
module ds_window_ctr #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [N:0]   cnt_o,
    output logic         wrap_o
);
    localparam int CW = N + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = &cnt_q[N-1:0];

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1)) else $error("step"); // R3
endmodule

// File: rtl/ds_capture.sv
module ds_capture #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic         ovr_i,
    input  logic [N-1:0] val_i,
    output logic         done_o,
    output logic [N-1:0] result_o,
    output logic         ovr_o
);
    typedef struct packed {
        logic         done;
        logic [N-1:0] result;
        logic         ovr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = cap_i;
        if (cap_i) begin
            cap_d.result = ovr_i ? {N{1'b1}} : val_i;
            cap_d.ovr    = ovr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign done_o   = cap_q.done;
    assign result_o = cap_q.result;
    assign ovr_o    = cap_q.ovr;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done pulse"); // R6
    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (result_o == {N{1'b1}})) else $error("ovr"); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(result_o) && $stable(ovr_o))) else $error("hold"); // R6
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         sel_ref_o,
    output logic [N:0]   count_o,
    output logic         done_o,
    output logic [N-1:0] result_o,
    output logic         ovr_o
);
    import ds_pkg::*;

    typedef struct packed {
        ds_state_e st;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic       clr, inc, cap, ovr;
    logic       wrap;
    logic [N:0] cnt;

    always_comb begin
        seq_d = seq_q;
        clr   = 1'b0;
        inc   = 1'b0;
        cap   = 1'b0;
        ovr   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr      = 1'b1;
                    seq_d.st = ST_INTEG;
                end
            end
            ST_INTEG: begin
                inc = 1'b1;
                if (wrap)
                    seq_d.st = ST_DEINT;
            end
            ST_DEINT: begin
                if (!cmp_i) begin
                    cap      = 1'b1;
                    seq_d.st = ST_IDLE;
                end else if (wrap) begin
                    cap      = 1'b1;
                    ovr      = 1'b1;
                    seq_d.st = ST_IDLE;
                end else begin
                    inc = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '{st: ST_IDLE};
        else
            seq_q <= seq_d;
    end

    ds_window_ctr #(.N(N)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .inc_i  (inc),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    ds_capture #(.N(N)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .ovr_i    (ovr),
        .val_i    (cnt[N-1:0]),
        .done_o   (done_o),
        .result_o (result_o),
        .ovr_o    (ovr_o)
    );

    assign count_o   = cnt;
    assign sel_ref_o = cnt[N];

    AST_INTEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_INTEG) |=> (count_o == $past(count_o) + 1'b1)) else $error("integ"); // R2
    AST_DEINT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DEINT) |-> sel_ref_o) else $error("sel"); // R1
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DEINT && !cmp_i) |=> ($stable(count_o) && done_o && !ovr_o)) else $error("freeze"); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && !start_i) |=> $stable(count_o)) else $error("idle"); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_INTEG && start_i) |=> (count_o != '0)) else $error("start"); // R7
endmodule

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
    localparam int N      = 6;
    localparam int WIN    = 1 << N;
    localparam int VREF   = 100;
    localparam int CLK_NS = 10;
    localparam int WDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic         sel_ref;
    logic [N:0]   count;
    logic         done;
    logic [N-1:0] result;
    logic         ovr;

    int vin = 0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    dual_slope_seq #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmp_i     (cmp),
        .sel_ref_o (sel_ref),
        .count_o   (count),
        .done_o    (done),
        .result_o  (result),
        .ovr_o     (ovr)
    );

    // behavioural integrator: after k reference cycles it holds vin*WIN - k*VREF
    always_comb begin
        int k;
        k = int'(count[N-1:0]);
        if (!count[N])
            cmp = 1'b1;
        else
            cmp = (vin * WIN > k * VREF);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int exp_k(input int v);
        return (v * WIN + VREF - 1) / VREF;
    endfunction

    task automatic convert(input int v, input int inject_at);
        int k;
        int cycles;
        bit over;
        bit seen;
        k    = exp_k(v);
        over = (k >= WIN);
        vin  = v;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        seen = 1'b0;
        chk(count == 0, "R2 clear", int'(count), 0);
        while (!seen && cycles < 4 * WIN) begin
            if (cycles == inject_at) start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cycles++;
            if (cycles == inject_at + 1)
                chk(int'(count) == cycles, "R7 start ignored", int'(count), cycles);
            if (cycles == WIN - 1)
                chk(!sel_ref && count == WIN - 1, "R1 input phase", int'(sel_ref), 0);
            if (cycles == WIN)
                chk(sel_ref && count == WIN, "R2 wrap to ref", int'(count), WIN);
            if (done) seen = 1'b1;
        end
        if (over) begin
            chk(cycles == 2 * WIN, "R5 ovr timing", cycles, 2 * WIN);
            chk(ovr && result == WIN - 1, "R5 clamp", int'(result), WIN - 1);
        end else begin
            chk(cycles == WIN + k + 1, "R3 trip timing", cycles, WIN + k + 1);
            chk(!ovr && int'(result) == k, "R4 result", int'(result), k);
            chk(int'(count) == WIN + k, "R4 frozen count", int'(count), WIN + k);
        end
        @(negedge clk);
        chk(!done, "R6 single pulse", int'(done), 0);
        chk(int'(count) == (over ? 2 * WIN - 1 : WIN + k), "R6 idle hold", int'(count),
            over ? 2 * WIN - 1 : WIN + k);
    endtask

    initial begin
        process::self().srandom(32'd7);
        #(CLK_NS * 3);
        chk(count == 0 && !sel_ref && !done && result == 0 && !ovr, "R8 reset",
            int'(count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == 0 && !done, "R8 after release", int'(count), 0);

        convert(0, -5);            // trip on first reference cycle
        convert(50, 20);           // start injected in first phase
        convert(98, WIN + 10);     // start injected in second phase
        convert(99, -5);           // rounds up to overrange
        convert(VREF, -5);         // full scale
        convert(1, -5);
        for (int i = 0; i < 12; i++)
            convert(int'($urandom_range(0, VREF)), -5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule